// File: doc/BRIEF.md
# Slice Speed Level Selector

This block decides how slowly the processor may run the next code slice of a real-time task without putting the task's deadline at risk. A task is cut into slices. Before each slice, software supplies five values:

- the slice's worst-case time at full speed;
- the summed worst-case time of every slice still to come after it;
- the time left until the task's virtual deadline;
- the speed level the previous slice ran at;
- the cost of a speed change.

All times are unsigned counts of one common tick.

The time this slice may use is the time to the deadline less the remaining-slices sum, floored at zero. The block prices three discrete levels: full, one half and one third of maximum speed. At each level the slice's worst-case time is stretched by the level's integer factor. The change cost is added only if that level differs from the previous slice's level. The block returns the slowest level whose price still fits the available time. If no level fits, it returns full speed and raises an overrun flag. The result is registered one cycle after a start pulse and is marked by a one-cycle valid strobe.

Top module: `slice_speed_sel`

## Requirements
- R1: The available time is `deadline_time - rest_wcet` when `deadline_time > rest_wcet`, and zero otherwise.
- R2: Level codes are 0 = full speed, 1 = half speed and 2 = one-third speed. The time a slice needs at level L is `slice_wcet * (L+1)`.
- R3: The change cost `switch_cost` is added to a level's needed time only when that level differs from `prev_level`. A `prev_level` of 3 matches no level, so the cost is always charged.
- R4: The chosen level is the highest-coded level whose needed time is less than or equal to the available time. Equality counts as a fit.
- R5: If no level fits, `speed_level` is 0 and `overrun` is 1. Otherwise `overrun` is 0.
- R6: `result_valid` is 1 in exactly the cycle after a cycle with `start` high, and 0 in every other cycle.
- R7: `speed_level` and `overrun` change only in the cycle after a start. They hold their values otherwise.
- R8: After reset, `result_valid` is 0, `speed_level` is 0 and `overrun` is 0.
- R9: The arithmetic does not wrap for any 32-bit operands, including the largest values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a decision from the current inputs |
| slice_wcet | input | 32 | Worst-case time of this slice at full speed |
| rest_wcet | input | 32 | Summed worst-case time of the later slices |
| deadline_time | input | 32 | Time left until the virtual deadline |
| prev_level | input | 2 | Level used by the previous slice |
| switch_cost | input | 32 | Time a speed change costs |
| speed_level | output | 2 | Chosen level (0 full, 1 half, 2 third) |
| overrun | output | 1 | No level meets the budget |
| result_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
The hardest cases are at the boundary of the budget. A level can fit only because the change cost is waived, since it equals the previous level. A level can also fit with zero margin. Both kinds appear only for narrow combinations of all five inputs. The bench therefore sweeps every combination of small slice times, remaining sums, deadlines, previous levels and change costs, so every exact-equality fit and every waived-cost fit is reached. A few hand-picked full-width operands then cover saturation and the absence of wraparound.

// File: rtl/slvl_pkg.sv
// Package: shared widths and level codes for the slice speed selector.
// Assumes at most four speed levels, so a level fits in two bits.
package slvl_pkg;
    localparam int LVL_W = 2;
    typedef logic [LVL_W-1:0] lvl_t;
    localparam lvl_t LVL_FULL = 2'd0;
endpackage

// File: rtl/slvl_budget.sv
// Module: time budget left for the current slice.
// Subtracts the later slices' worst case from the deadline distance and floors the result at zero.
module slvl_budget #(
    parameter int TW = 32
) (
    input  logic [TW-1:0] deadline_time,
    input  logic [TW-1:0] rest_wcet,
    output logic [TW-1:0] avail
);
    // Saturating subtraction.
    always_comb begin
        if (deadline_time > rest_wcet) avail = deadline_time - rest_wcet;
        else                           avail = '0;
    end
endmodule

// File: rtl/slvl_cost.sv
// Module: price of running the slice at one speed level, and whether that price fits.
// Assumes CW leaves room for TW * MULT plus one TW-wide delay term, so nothing wraps.
module slvl_cost
    import slvl_pkg::*;
#(
    parameter int TW   = 32,
    parameter int CW   = 35,
    parameter int MULT = 1,
    parameter int IDX  = 0
) (
    input  logic [TW-1:0] slice_wcet,
    input  logic [TW-1:0] switch_cost,
    input  lvl_t          prev_level,
    input  logic [TW-1:0] avail,
    output logic          fits
);
    logic [CW-1:0] scaled;
    logic [CW-1:0] need;
    logic          charge;

    // Stretch the worst case by the level factor, then add the change cost when the level changes.
    always_comb begin
        scaled = CW'(slice_wcet) * CW'(MULT);
        charge = (prev_level != LVL_W'(IDX));
        need   = scaled + (charge ? CW'(switch_cost) : '0);
        fits   = (need <= CW'(avail));
    end
endmodule

// File: rtl/slvl_pick.sv
// Module: choose the slowest level that fits, or report that none fits.
// Assumes the bit index of the fit vector is the level code and higher codes are slower.
module slvl_pick
    import slvl_pkg::*;
#(
    parameter int NL = 3
) (
    input  logic [NL-1:0] fit,
    output lvl_t          level,
    output logic          none
);
    // A later (slower) fitting level overrides an earlier one.
    always_comb begin
        level = LVL_FULL;
        none  = 1'b1;
        for (int i = 0; i < NL; i++) begin
            if (fit[i]) begin
                level = LVL_W'(i);
                none  = 1'b0;
            end
        end
    end
endmodule

// File: rtl/slice_speed_sel.sv
// Module: slice speed level selector (top).
// Prices every level in parallel, picks the slowest one that fits, and registers the result on start.
// Assumes inputs are stable in the cycle start is high and NLEVELS <= 4.
module slice_speed_sel
    import slvl_pkg::*;
#(
    parameter int TW      = 32,
    parameter int NLEVELS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] slice_wcet,
    input  logic [TW-1:0] rest_wcet,
    input  logic [TW-1:0] deadline_time,
    input  logic [1:0]    prev_level,
    input  logic [TW-1:0] switch_cost,
    output logic [1:0]    speed_level,
    output logic          overrun,
    output logic          result_valid
);
    localparam int CW = TW + $clog2(NLEVELS + 1) + 1;

    logic [TW-1:0]      avail;
    logic [NLEVELS-1:0] fit;
    lvl_t               pick_lvl;
    logic               pick_none;

    slvl_budget #(.TW(TW)) u_budget (
        .deadline_time(deadline_time),
        .rest_wcet    (rest_wcet),
        .avail        (avail)
    );

    for (genvar g = 0; g < NLEVELS; g++) begin : g_lvl
        slvl_cost #(.TW(TW), .CW(CW), .MULT(g + 1), .IDX(g)) u_cost (
            .slice_wcet (slice_wcet),
            .switch_cost(switch_cost),
            .prev_level (prev_level),
            .avail      (avail),
            .fits       (fit[g])
        );
    end

    slvl_pick #(.NL(NLEVELS)) u_pick (
        .fit  (fit),
        .level(pick_lvl),
        .none (pick_none)
    );

    // Capture the decision on start; the strobe follows start by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            speed_level  <= LVL_FULL;
            overrun      <= 1'b0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= start;
            if (start) begin
                speed_level <= pick_lvl;
                overrun     <= pick_none;
            end
        end
    end

    a_r6_valid_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> result_valid);
    a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !result_valid);
    a_r7_hold_between_starts: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(speed_level) && $stable(overrun)));
    a_r5_overrun_at_full: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> (speed_level == LVL_FULL));
    a_r4_level_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (int'(speed_level) < NLEVELS));
endmodule

// File: tb/tb_slice_speed_sel.sv
module tb_slice_speed_sel;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] slice_wcet = '0, rest_wcet = '0, deadline_time = '0, switch_cost = '0;
    logic [1:0]  prev_level = '0;
    logic [1:0]  speed_level;
    logic        overrun, result_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    slice_speed_sel dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .slice_wcet(slice_wcet), .rest_wcet(rest_wcet), .deadline_time(deadline_time),
        .prev_level(prev_level), .switch_cost(switch_cost),
        .speed_level(speed_level), .overrun(overrun), .result_valid(result_valid)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference model built from R1..R5 with wide integers.
    task automatic model(input longint w, input longint r, input longint d, input int p,
                         input longint c, output int lvl, output int ovr);
        longint av;
        longint need;
        av  = (d > r) ? d - r : 0;   // R1
        lvl = 0;
        ovr = 1;
        for (int k = 0; k < 3; k++) begin
            need = w * (k + 1) + ((p == k) ? 0 : c);   // R2, R3
            if (need <= av) begin lvl = k; ovr = 0; end  // R4
        end
    endtask

    // Runs one decision: a start pulse, a result check, then a hold check (R6, R7).
    task automatic run_case(input logic [31:0] w, input logic [31:0] r, input logic [31:0] d,
                            input logic [1:0] p, input logic [31:0] c, input string tag);
        int el, eo;
        model(longint'(w), longint'(r), longint'(d), int'(p), longint'(c), el, eo);
        slice_wcet = w; rest_wcet = r; deadline_time = d; prev_level = p; switch_cost = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({"R6 valid ", tag}, result_valid, 1);
        check({"R4 level ", tag}, speed_level, el);
        check({"R5 overrun ", tag}, overrun, eo);
        // Disturb the inputs without start; the outputs must not move.
        slice_wcet = ~w; deadline_time = ~d; prev_level = ~p;
        @(negedge clk);
        check({"R6 strobe drop ", tag}, result_valid, 0);
        check({"R7 hold level ", tag}, speed_level, el);
        check({"R7 hold overrun ", tag}, overrun, eo);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state.
        check("R8 valid", result_valid, 0);
        check("R8 level", speed_level, 0);
        check("R8 overrun", overrun, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 idle valid", result_valid, 0);

        // Sweep of small operands covers R1..R7, including exact fits and waived costs.
        for (int w = 0; w < 6; w++)
            for (int r = 0; r < 5; r++)
                for (int d = 0; d < 21; d++)
                    for (int p = 0; p < 4; p++)
                        for (int c = 0; c < 4; c++)
                            run_case(32'(w), 32'(r), 32'(d), 2'(p), 32'(c), "sweep R1 R2 R3");

        // R1: deadline far below the remaining sum saturates the budget at zero.
        run_case(32'd0, 32'hFFFF_FFFF, 32'd5, 2'd0, 32'd0, "R1 saturate");
        // R9: full-width operands must not wrap.
        run_case(32'hFFFF_FFFF, 32'd0, 32'hFFFF_FFFF, 2'd3, 32'd0, "R9 max wcet");
        run_case(32'h6000_0000, 32'd0, 32'hFFFF_FFFF, 2'd2, 32'hFFFF_FFFF, "R9 big cost");
        run_case(32'h5555_5555, 32'd0, 32'hFFFF_FFFF, 2'd2, 32'hFFFF_FFFF, "R9 exact third");
        run_case(32'h8000_0000, 32'd1, 32'hFFFF_FFFF, 2'd1, 32'd0, "R9 half wrap");
        run_case(32'd1, 32'd0, 32'd2, 2'd3, 32'hFFFF_FFFF, "R9 R3 huge cost");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule